// File: doc/BRIEF.md
# Bit-Serial SIMD Processing Element Array

The block is an array of small bit-serial processing elements. All of them obey one command stream issued by an outside sequencer. Each element keeps a private row of 8-bit weights and a 16-bit accumulator. It also has a bit-serial adder and a carry-save serial-parallel multiplier. A multiply-and-accumulate step therefore finishes in the same 16 bit cycles as a plain add, and the multiplier and the adder run side by side in those cycles.

Communication across the array takes three forms:
- **Broadcast:** one bit per cycle, taken from the element picked by a selection pointer, goes to every element.
- **Selection:** the pointer steps through the elements in index order.
- **Sum:** a registered bit-serial adder tree adds the accumulators of all elements.

The broadcast stream also appears at the ports as a parallel word, which is how accumulators are read out. A per-element activity flag protects an element's accumulator from arithmetic and clearing commands. A host loads weights through a plain write port.

Commands are accepted when `cmd_valid` and `cmd_ready` are both high. Serial commands hold `cmd_ready` low while they run. Their results appear as registered words with a one-cycle valid pulse.

Top module: `simd_pe_array`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `bc_valid` and `sum_valid` are 0. Every accumulator reads 0, every element is active, and the selection pointer is 0.
- R2: Opcode 2 (add) adds the zero-extended weight word at `cmd_addr` to each active accumulator, modulo 2^16. `cmd_ready` stays low for 16 cycles after acceptance.
- R3: Opcode 3 (multiply-accumulate) adds weight[`cmd_addr`] × `cmd_imm` (both unsigned 8-bit) to each active accumulator, modulo 2^16. It keeps `cmd_ready` low for the same 16 cycles as an add.
- R4: Opcode 4 (broadcast multiply-accumulate) adds weight[`cmd_addr`] × the low 8 bits of the selected element's accumulator, taken as it stood before the command, to each active accumulator. `bc_data` returns that selected accumulator's prior value.
- R5: Opcode 5 (read) leaves all accumulators unchanged and returns the selected element's accumulator on `bc_data`. `bc_valid` is a one-cycle pulse that coincides with `cmd_ready` returning high.
- R6: Opcode 7 (select) takes one cycle. With `cmd_imm[0]`=0 it sets the pointer to 0. With `cmd_imm[0]`=1 it advances the pointer by one, wrapping from the last element to 0.
- R7: Opcode 6 (sum) returns the 20-bit sum of all 16 accumulators on `sum_data`, with a one-cycle `sum_valid` pulse. `cmd_ready` stays low for 24 cycles, which is 16 plus twice the tree depth.
- R8: An inactive element's accumulator is untouched by opcodes 1 to 4. Opcode 8 sets the selected element's activity flag to `cmd_imm[0]`. Opcode 9 sets every element's flag to `cmd_imm[0]`.
- R9: Opcode 1 (clear) zeroes every active accumulator in one cycle. Opcode 0 does nothing.
- R10: `wr_en` writes `wr_data` into word `wr_addr` of element `wr_pe`. Later commands use the written value.
- R11: A command offered while `cmd_ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host weight write strobe |
| wr_pe | input | 4 | Element addressed by the host write |
| wr_addr | input | 4 | Weight word index |
| wr_data | input | 8 | Weight value |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | 4 | Weight word used by the command |
| cmd_imm | input | 8 | Immediate operand or flag |
| cmd_ready | output | 1 | Array idle, command can be taken |
| bc_valid | output | 1 | Broadcast word valid pulse |
| bc_data | output | 16 | Broadcast accumulator word |
| sum_valid | output | 1 | Tree sum valid pulse |
| sum_data | output | 20 | Sum of all accumulators |

## Verification
Counting from the clock edge that accepts a command, add, multiply-accumulate, broadcast multiply-accumulate and read hold `cmd_ready` low for 16 cycles. A sum holds it low for 24 cycles. The result word and its valid pulse appear in the cycle after the last busy cycle.

The driver counts the falling edges on which `cmd_ready` is low and compares that count with the expected length. Before each command it queues the expected word. The monitor compares the word only on the falling edge where the valid pulse is high. Single-cycle commands are checked through a later read, not at a fixed offset.

// File: rtl/pe_array_pkg.sv
package pe_array_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_CLR  = 4'd1,
    OP_ADD  = 4'd2,
    OP_MAC  = 4'd3,
    OP_MACB = 4'd4,
    OP_READ = 4'd5,
    OP_SUM  = 4'd6,
    OP_SEL  = 4'd7,
    OP_MSEL = 4'd8,
    OP_MALL = 4'd9
  } op_e;

  function automatic logic is_serial(input logic [3:0] op);
    return op == OP_ADD || op == OP_MAC || op == OP_MACB ||
           op == OP_READ || op == OP_SUM;
  endfunction
endpackage

// File: rtl/pe_cs_mul.sv
// Serial-parallel carry-save multiplier: parallel operand a, serial operand x
// LSB first, one product bit per cycle with no carry ripple across cells.
module pe_cs_mul #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] a,
  input  logic         x,
  output logic         p
);
  logic [W-2:0] s_q;
  logic [W-1:0] c_q;
  logic [W-1:0] sin, fs, fc, pp;

  for (genvar i = 0; i < W; i++) begin : g_cell
    if (i == W - 1) begin : g_top
      assign sin[i] = 1'b0;
    end else begin : g_mid
      assign sin[i] = s_q[i];
    end
    assign pp[i] = a[i] & x;
    assign fs[i] = pp[i] ^ sin[i] ^ c_q[i];
    assign fc[i] = (pp[i] & sin[i]) | (pp[i] & c_q[i]) | (sin[i] & c_q[i]);
  end

  assign p = fs[0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      s_q <= '0;
      c_q <= '0;
    end else if (en) begin
      s_q <= fs[W-1:1];
      c_q <= fc;
    end
  end

  AST_MUL_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (s_q == '0 && c_q == '0 && !x) |-> !p); // R3
endmodule

// File: rtl/pe_cell.sv
module pe_cell #(
  parameter int W     = 8,
  parameter int ACC_W = 16,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [W-1:0]             wr_data,
  input  logic                     start,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  input  logic                     rot,
  input  logic                     upd,
  input  logic                     use_mul,
  input  logic [CW-1:0]            bitpos,
  input  logic                     x_bit,
  input  logic                     clr_acc,
  input  logic                     m_we,
  input  logic                     m_val,
  output logic                     lsb
);
  logic [W-1:0]     mem [DEPTH];
  logic [W-1:0]     w_q;
  logic [W-1:0]     w_sh;
  logic [ACC_W-1:0] acc_q;
  logic             act_q, c_q, prod, b_in, s_bit, c_nxt;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (start) w_q <= mem[rd_addr];
  end

  pe_cs_mul #(.W(W)) u_mul (
    .clk(clk), .rst(rst), .clr(start), .en(rot && use_mul),
    .a(w_q), .x(x_bit), .p(prod)
  );

  assign w_sh  = w_q >> bitpos;
  assign b_in  = use_mul ? prod : w_sh[0];
  assign s_bit = acc_q[0] ^ b_in ^ c_q;
  assign c_nxt = (acc_q[0] & b_in) | (acc_q[0] & c_q) | (b_in & c_q);
  assign lsb   = acc_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      act_q <= 1'b1;
      c_q   <= 1'b0;
    end else begin
      if (m_we) act_q <= m_val;
      if (clr_acc && act_q) acc_q <= '0;
      if (start) begin
        c_q <= 1'b0;
      end else if (rot) begin
        if (upd && act_q) begin
          acc_q <= {s_bit, acc_q[ACC_W-1:1]};
          c_q   <= c_nxt;
        end else begin
          acc_q <= {acc_q[0], acc_q[ACC_W-1:1]};
        end
      end
    end
  end

  AST_INACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!act_q && !rot && !m_we) |=> $stable(acc_q)); // R8
endmodule

// File: rtl/pe_sum_tree.sv
// Bit-serial adder tree, one registered full adder per node per level.
module pe_sum_tree #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [N-1:0] leaf,
  output logic         root
);
  localparam int LG = $clog2(N);

  for (genvar l = 1; l <= LG; l++) begin : lvl
    localparam int M = N >> l;
    logic [M-1:0]   s_q, c_q, fs, fc;
    logic [2*M-1:0] in_b;
    if (l == 1) begin : g_leaf
      assign in_b = leaf;
    end else begin : g_inner
      assign in_b = lvl[l-1].s_q;
    end
    for (genvar j = 0; j < M; j++) begin : g_node
      assign fs[j] = in_b[2*j] ^ in_b[2*j+1] ^ c_q[j];
      assign fc[j] = (in_b[2*j] & in_b[2*j+1]) | (in_b[2*j] & c_q[j]) |
                     (in_b[2*j+1] & c_q[j]);
    end
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        s_q <= '0;
        c_q <= '0;
      end else if (en) begin
        s_q <= fs;
        c_q <= fc;
      end
    end
  end

  assign root = lvl[LG].s_q[0];
endmodule

// File: rtl/simd_pe_array.sv
module simd_pe_array
  import pe_array_pkg::*;
#(
  parameter int N_PE  = 16,
  parameter int W     = 8,
  parameter int ACC_W = 16,
  parameter int DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [$clog2(N_PE)-1:0]       wr_pe,
  input  logic [$clog2(DEPTH)-1:0]      wr_addr,
  input  logic [W-1:0]                  wr_data,
  input  logic                          cmd_valid,
  input  logic [3:0]                    cmd_op,
  input  logic [$clog2(DEPTH)-1:0]      cmd_addr,
  input  logic [W-1:0]                  cmd_imm,
  output logic                          cmd_ready,
  output logic                          bc_valid,
  output logic [ACC_W-1:0]              bc_data,
  output logic                          sum_valid,
  output logic [ACC_W+$clog2(N_PE)-1:0] sum_data
);
  localparam int LG      = $clog2(N_PE);
  localparam int SW      = ACC_W + LG;
  localparam int LEN_SUM = ACC_W + 2 * LG;
  localparam int CW      = $clog2(LEN_SUM + 1);

  logic            ready_q;
  logic [3:0]      op_q;
  logic [CW-1:0]   cnt_q, len;
  logic [W-1:0]    imm_q, imm_sh;
  logic [LG-1:0]   sel_q;
  logic [ACC_W-1:0] bc_sh;
  logic [SW-1:0]   sum_sh;
  logic [N_PE-1:0] pe_lsb, leaf;
  logic accept, start, run, last, rot, bcast, x_bit, root, bc_op;

  assign accept = cmd_valid && ready_q;
  assign start  = accept && is_serial(cmd_op);
  assign run    = !ready_q;
  assign len    = (op_q == OP_SUM) ? CW'(LEN_SUM) : CW'(ACC_W);
  assign last   = run && (cnt_q == len - 1'b1);
  assign rot    = run && (cnt_q < CW'(ACC_W));
  assign bcast  = pe_lsb[sel_q];
  assign imm_sh = imm_q >> cnt_q;
  assign x_bit  = (op_q == OP_MAC) ? imm_sh[0] : (bcast && cnt_q < CW'(W));
  assign leaf   = rot ? pe_lsb : '0;
  assign bc_op  = (op_q == OP_READ) || (op_q == OP_MACB);

  for (genvar i = 0; i < N_PE; i++) begin : g_pe
    pe_cell #(.W(W), .ACC_W(ACC_W), .DEPTH(DEPTH), .CW(CW)) u_pe (
      .clk(clk), .rst(rst),
      .wr_en(wr_en && wr_pe == LG'(i)), .wr_addr(wr_addr), .wr_data(wr_data),
      .start(start), .rd_addr(cmd_addr), .rot(rot),
      .upd(op_q == OP_ADD || op_q == OP_MAC || op_q == OP_MACB),
      .use_mul(op_q == OP_MAC || op_q == OP_MACB),
      .bitpos(cnt_q), .x_bit(x_bit),
      .clr_acc(accept && cmd_op == OP_CLR),
      .m_we(accept && (cmd_op == OP_MALL || (cmd_op == OP_MSEL && sel_q == LG'(i)))),
      .m_val(cmd_imm[0]),
      .lsb(pe_lsb[i])
    );
  end

  pe_sum_tree #(.N(N_PE)) u_tree (
    .clk(clk), .rst(rst), .clr(start), .en(run && op_q == OP_SUM),
    .leaf(leaf), .root(root)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b1;
      op_q      <= OP_NOP;
      cnt_q     <= '0;
      imm_q     <= '0;
      sel_q     <= '0;
      bc_sh     <= '0;
      sum_sh    <= '0;
      bc_valid  <= 1'b0;
      bc_data   <= '0;
      sum_valid <= 1'b0;
      sum_data  <= '0;
    end else begin
      bc_valid  <= 1'b0;
      sum_valid <= 1'b0;
      if (accept) begin
        if (is_serial(cmd_op)) begin
          ready_q <= 1'b0;
          op_q    <= cmd_op;
          cnt_q   <= '0;
          imm_q   <= cmd_imm;
        end
        if (cmd_op == OP_SEL) sel_q <= cmd_imm[0] ? sel_q + 1'b1 : '0;
      end
      if (run) begin
        cnt_q <= cnt_q + 1'b1;
        if (bc_op) bc_sh <= {bcast, bc_sh[ACC_W-1:1]};
        if (op_q == OP_SUM && cnt_q >= CW'(LG)) sum_sh <= {root, sum_sh[SW-1:1]};
        if (last) begin
          ready_q <= 1'b1;
          if (bc_op) begin
            bc_valid <= 1'b1;
            bc_data  <= {bcast, bc_sh[ACC_W-1:1]};
          end
          if (op_q == OP_SUM) begin
            sum_valid <= 1'b1;
            sum_data  <= {root, sum_sh[SW-1:1]};
          end
        end
      end
    end
  end

  assign cmd_ready = ready_q;

  AST_SERIAL_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |=> !cmd_ready); // R2
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (!cmd_ready && cmd_valid && !last) |=> !cmd_ready); // R11
  AST_SEL_RESTART: assert property (@(posedge clk) disable iff (rst)
    (accept && cmd_op == OP_SEL && !cmd_imm[0]) |=> sel_q == '0); // R6
  AST_BC_PULSE: assert property (@(posedge clk) disable iff (rst)
    bc_valid |-> (cmd_ready && $past(!cmd_ready))); // R5
  AST_SUM_PULSE: assert property (@(posedge clk) disable iff (rst)
    sum_valid |=> !sum_valid); // R7
endmodule

// File: tb/sim_simd_pe_array.sv
`timescale 1ns/1ps
module sim_simd_pe_array;
  localparam logic [3:0] K_NOP = 4'd0, K_CLR = 4'd1, K_ADD = 4'd2, K_MAC = 4'd3,
    K_MACB = 4'd4, K_READ = 4'd5, K_SUM = 4'd6, K_SEL = 4'd7, K_MSEL = 4'd8, K_MALL = 4'd9;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [3:0] wr_pe = '0, wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0, cmd_addr = '0;
  logic [7:0] cmd_imm = '0;
  logic cmd_ready, bc_valid, sum_valid;
  logic [15:0] bc_data;
  logic [19:0] sum_data;

  always #2.5 clk = ~clk;

  simd_pe_array u0 (.*);

  int n_chk = 0, n_fail = 0;
  logic [15:0] acc_m [16];
  logic [7:0]  mem_m [16][16];
  bit          act_m [16];
  int          sel_m = 0;
  logic [15:0] exp_bc_q [$];
  string       tag_bc_q [$];
  logic [19:0] exp_sum_q [$];
  string       tag_sum_q [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected words when a result pulse appears
  always @(negedge clk) begin
    if (!rst) begin
      if (bc_valid) begin
        if (exp_bc_q.size() == 0) chk(0, "R5 unexpected bc_valid", 1, 0);
        else begin
          automatic logic [15:0] e = exp_bc_q.pop_front();
          automatic string t = tag_bc_q.pop_front();
          chk(bc_data == e, t, bc_data, e);
        end
      end
      if (sum_valid) begin
        if (exp_sum_q.size() == 0) chk(0, "R7 unexpected sum_valid", 1, 0);
        else begin
          automatic logic [19:0] e = exp_sum_q.pop_front();
          automatic string t = tag_sum_q.pop_front();
          chk(sum_data == e, t, sum_data, e);
        end
      end
    end
  end

  task automatic issue(input logic [3:0] op, input int addr, input int imm, input bit noise);
    int lowcnt, exp_len;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = 4'(addr); cmd_imm = 8'(imm);
    @(negedge clk);
    cmd_valid = 1'b0;
    lowcnt = 0;
    while (!cmd_ready) begin
      lowcnt++;
      if (noise && lowcnt < 3) begin
        cmd_valid = 1'b1; cmd_op = K_CLR;  // R11: must be ignored
      end else cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    exp_len = (op == K_SUM) ? 24 :
              (op == K_ADD || op == K_MAC || op == K_MACB || op == K_READ) ? 16 : 0;
    if (op == K_ADD) chk(lowcnt == exp_len, "R2 busy length", lowcnt, exp_len);
    else if (op == K_MAC || op == K_MACB) chk(lowcnt == exp_len, "R3 busy length", lowcnt, exp_len);
    else if (op == K_SUM) chk(lowcnt == exp_len, "R7 busy length", lowcnt, exp_len);
    else chk(lowcnt == exp_len, "R6 single cycle command", lowcnt, exp_len);
  endtask

  task automatic host_wr(input int pe, input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_pe = 4'(pe); wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    mem_m[pe][a] = 8'(d);
  endtask

  task automatic sel(input bit adv);
    sel_m = adv ? (sel_m + 1) % 16 : 0;
    issue(K_SEL, 0, adv, 0);
  endtask

  task automatic rd(input string tag);
    exp_bc_q.push_back(acc_m[sel_m]); tag_bc_q.push_back(tag);
    issue(K_READ, 0, 0, 0);
  endtask

  task automatic read_all(input string tag);
    sel(0);
    for (int i = 0; i < 16; i++) begin
      rd(tag);
      sel(1);
    end
  endtask

  task automatic mac(input int a, input int x, input bit noise);
    for (int j = 0; j < 16; j++)
      if (act_m[j]) acc_m[j] = acc_m[j] + 16'(mem_m[j][a] * x);
    issue(K_MAC, a, x, noise);
  endtask

  task automatic add(input int a);
    for (int j = 0; j < 16; j++)
      if (act_m[j]) acc_m[j] = acc_m[j] + 16'(mem_m[j][a]);
    issue(K_ADD, a, 0, 0);
  endtask

  task automatic clr;
    for (int j = 0; j < 16; j++) if (act_m[j]) acc_m[j] = '0;
    issue(K_CLR, 0, 0, 0);
  endtask

  task automatic macb(input int a, input string tag);
    logic [7:0] bx;
    bx = acc_m[sel_m][7:0];
    exp_bc_q.push_back(acc_m[sel_m]); tag_bc_q.push_back(tag);
    for (int j = 0; j < 16; j++)
      if (act_m[j]) acc_m[j] = acc_m[j] + 16'(mem_m[j][a] * bx);
    issue(K_MACB, a, 0, 0);
  endtask

  task automatic sum(input string tag);
    logic [19:0] s;
    s = '0;
    for (int j = 0; j < 16; j++) s = s + 20'(acc_m[j]);
    exp_sum_q.push_back(s); tag_sum_q.push_back(tag);
    issue(K_SUM, 0, 0, 0);
  endtask

  task automatic set_mask_one(input int pe, input bit v);
    sel(0);
    for (int i = 0; i < pe; i++) sel(1);
    act_m[pe] = v;
    issue(K_MSEL, 0, v, 0);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < 16; j++) begin acc_m[j] = '0; act_m[j] = 1; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state at the ports
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    chk(bc_valid == 1'b0, "R1 bc_valid after reset", bc_valid, 0);
    chk(sum_valid == 1'b0, "R1 sum_valid after reset", sum_valid, 0);
    rd("R1 pointer and accumulator zero");
    read_all("R1 accumulators zero");
    sum("R1 tree sum zero");

    // R10 host load of weight rows
    for (int i = 0; i < 16; i++)
      for (int k = 0; k < 6; k++) host_wr(i, k, (i * 37 + k * 11 + 5) & 255);

    // R3 dot product of each weight row with an input vector
    mac(0, 3, 0); mac(1, 200, 0); mac(2, 17, 0); mac(3, 255, 0);
    read_all("R3 dot product");
    add(2);
    read_all("R2 add weight word");
    sum("R7 tree sum of dot products");

    // R8 masking: element 3 inactive, then all inactive
    set_mask_one(3, 0);
    mac(4, 9, 0);
    clr;
    read_all("R8 R9 mask protects, clear zeroes");
    issue(K_MALL, 0, 0, 0);
    for (int j = 0; j < 16; j++) act_m[j] = 0;
    add(5);
    read_all("R8 all inactive");
    issue(K_MALL, 0, 1, 0);
    for (int j = 0; j < 16; j++) act_m[j] = 1;
    issue(K_NOP, 0, 0, 0);
    read_all("R9 nop leaves state");

    // R4 broadcast multiply-accumulate from element 5
    clr;
    add(1);
    sel(0);
    for (int i = 0; i < 5; i++) sel(1);
    macb(0, "R4 broadcast source word");
    read_all("R4 broadcast products");

    // R6 pointer wrap: 16 advances return to element 0
    sel(0);
    for (int i = 0; i < 16; i++) sel(1);
    rd("R6 pointer wrap to element 0");
    sel(1);
    rd("R6 pointer advance to element 1");

    // R11 commands during busy ignored
    mac(2, 5, 1);
    read_all("R11 busy command ignored");

    // R7 wide sum with carries into the upper bits
    clr;
    for (int i = 0; i < 16; i++) host_wr(i, 7, 255);
    mac(7, 255, 0); mac(7, 255, 0); add(7);
    sum("R7 wide tree sum");
    rd("R5 read leaves accumulators");
    sum("R5 R7 sum after read");

    repeat (4) @(negedge clk);
    chk(exp_bc_q.size() == 0, "R5 all broadcasts returned", exp_bc_q.size(), 0);
    chk(exp_sum_q.size() == 0, "R7 all sums returned", exp_sum_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule